// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Slave

This block receives 16-bit configuration words over a three-wire serial bus made of a serial clock, a data line and an active-low enable. All three lines are asynchronous to the block's system clock. Each line passes through a two-flop synchronizer, and the block detects edges in the system clock domain. While the enable line is low, every rising edge of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. When the enable line rises, the register addressed by the word's two least significant bits takes the 14-bit payload.

The four registers hold three things. Two of them hold the two halves of a 28-bit fractional divide word. One holds an 8-bit integer divide value together with six opaque setting bits. The last holds three software control bits and eleven opaque configuration bits.

The block also produces per-subsystem enables. Each enable is the AND of a hardware pin and a software bit. A software power-down bit turns off every subsystem. A low on the hardware shutdown pin overrides everything and also freezes the serial interface.

Top module: `tw_cfg_slave`

## Requirements
- R1: After reset: frac_word is 0, int_div is 35, aux_div is 0, cfg_aux is 0, and the software bits are BE=0, TE=1, PD=1. With all pins high this gives core_en=1, mod_en=1, syn_en=1 and buf_en=0.
- R2: While sen_n is low, each rising edge of sclk shifts sdata into bit 0 of the shift register and moves the older bits up. A full word is therefore sent most significant bit first.
- R3: A rising edge of sen_n commits the shift register to the register selected by word bits [1:0]. Address 0 loads word[15:2] into frac_word[27:14]. Address 1 loads word[15:2] into frac_word[13:0]. The other registers keep their values.
- R4: Address 2 loads word[9:2] into int_div and word[15:10] into aux_div.
- R5: Address 3 sets BE from word bit 2, TE from word bit 3 and PD from word bit 4, and loads word[15:5] into cfg_aux.
- R6: Rising edges of sclk while sen_n is high leave the shift register unchanged.
- R7: If fewer than 16 bits were shifted before sen_n rises, the commit uses the shift register as it stands. That value is the older contents moved up by the number of new bits.
- R8: core_en = hw_shdn_n AND PD. mod_en = core_en AND hw_txen AND TE.
- R9: buf_en = core_en AND hw_bufen AND BE.
- R10: syn_en = core_en AND hw_synen. A low hw_synen does not change mod_en.
- R11: While hw_shdn_n is low, all enables are low, and serial shifts and commits are ignored. The registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous |
| sdata | input | 1 | Serial data, asynchronous |
| sen_n | input | 1 | Serial enable, active low, asynchronous |
| hw_shdn_n | input | 1 | Chip-wide shutdown pin, active low |
| hw_txen | input | 1 | Modulator enable pin |
| hw_synen | input | 1 | Synthesizer enable pin |
| hw_bufen | input | 1 | LO buffer enable pin |
| frac_word | output | 28 | Fractional divide word |
| int_div | output | 8 | Integer divide value |
| aux_div | output | 6 | Opaque divider and charge-pump bits |
| cfg_aux | output | 11 | Opaque configuration bits |
| core_en | output | 1 | Enable for all non-interface circuits |
| mod_en | output | 1 | Modulator enable |
| syn_en | output | 1 | Synthesizer enable |
| buf_en | output | 1 | LO buffer enable |

## Verification
Shift-register corruption stays hidden until a commit. It then shows as a wrong field in the register that the committed address selects, three system clocks after the enable line rises at the pin. Short writes and edges sent while the enable line is high are used to make such a fault show in a known field.

A wrong address decode shows as a write to the wrong output field, while the intended field keeps its old value. Enable-combination faults are combinational, so they show within a cycle of a pin or software-bit change. The bench therefore sweeps the pin and bit combinations after every configuration write.

// File: rtl/tw_cfg_pkg.sv
// Package: widths, field positions and power-up values shared by the
// three-wire configuration slave. Assumes a 2-bit address in the word LSBs.
package tw_cfg_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;
    localparam int FRAC_W = 2 * PAY_W;
    localparam int INT_W  = 8;
    localparam int AUXD_W = PAY_W - INT_W;
    localparam int NSW    = 3;
    localparam int CFGA_W = PAY_W - NSW;

    // Position of each software control bit inside the address-3 payload
    localparam int BE_POS = 0;
    localparam int TE_POS = 1;
    localparam int PD_POS = 2;

    localparam logic [INT_W-1:0] INT_RST = 8'd35;
    localparam logic [PAY_W-1:0] CFG_RST = PAY_W'(14'b00_0000_0000_0110);

    typedef enum logic [ADDR_W-1:0] {
        A_FRAC_HI = 2'b00,
        A_FRAC_LO = 2'b01,
        A_DIVIDE  = 2'b10,
        A_CONFIG  = 2'b11
    } reg_addr_t;
endpackage

// File: rtl/tw_sync.sv
// Module: tw_sync
// Brings N asynchronous lines into the clk domain through two flops. It adds
// a third flop for edge detection and reports synced levels, rises and falls.
// Assumes each input level is held for at least two clk periods.
module tw_sync #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] st1, st2, st3;

    // Three-stage shift of every line: two for metastability, one for edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1 <= RST_VAL;
            st2 <= RST_VAL;
            st3 <= RST_VAL;
        end else begin
            st1 <= async_in;
            st2 <= st1;
            st3 <= st2;
        end
    end

    // Edge flags per line
    always_comb begin
        lvl  = st2;
        rise = st2 & ~st3;
        fall = ~st2 & st3;
    end

    // An edge flag is a single-cycle pulse
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chk
            rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rise[gi] |=> !rise[gi]);
        end
    endgenerate
endmodule

// File: rtl/tw_shift.sv
// Module: tw_shift
// Serial-in shift register for one word, MSB first. Shifts one bit per
// qualified serial clock edge. Its contents are never cleared, so a short
// transfer keeps the older bits moved up.
module tw_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    // Shift in a new bit at the LSB on each qualified edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (shift_en)
            word <= {word[W-2:0], din};
    end

    // R6: the contents hold whenever no qualified edge arrives
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/tw_regfile.sv
// Module: tw_regfile
// The four addressed configuration registers. On a write strobe, the payload
// goes to the register that the word's low address bits select. Assumes the
// strobe is one cycle wide.
module tw_regfile
    import tw_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    output logic [FRAC_W-1:0] frac_word,
    output logic [INT_W-1:0]  int_div,
    output logic [AUXD_W-1:0] aux_div,
    output logic [PAY_W-1:0]  cfg_pay
);
    reg_addr_t        addr;
    logic [PAY_W-1:0] pay;

    // Split the word into address and payload
    always_comb begin
        addr = reg_addr_t'(word[ADDR_W-1:0]);
        pay  = word[WORD_W-1:ADDR_W];
    end

    // Address decode and register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_word <= '0;
            int_div   <= INT_RST;
            aux_div   <= '0;
            cfg_pay   <= CFG_RST;
        end else if (wr_en) begin
            case (addr)
                A_FRAC_HI: frac_word[FRAC_W-1:PAY_W] <= pay;
                A_FRAC_LO: frac_word[PAY_W-1:0]      <= pay;
                A_DIVIDE:  {aux_div, int_div}        <= pay;
                default:   cfg_pay                   <= pay;
            endcase
        end
    end

    // R3
    commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({frac_word, int_div, aux_div, cfg_pay}));
    // R3
    frac_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word[ADDR_W-1:0] == 2'b00) |=>
        (frac_word[FRAC_W-1:PAY_W] == $past(word[WORD_W-1:ADDR_W])) && $stable(int_div));
endmodule

// File: rtl/tw_enables.sv
// Module: tw_enables
// Combines the hardware enable pins with the software control bits into the
// per-subsystem enables. It is purely combinational, so a pin change shows
// within the same cycle.
module tw_enables (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_shdn_n,
    input  logic hw_txen,
    input  logic hw_synen,
    input  logic hw_bufen,
    input  logic sw_pd,
    input  logic sw_te,
    input  logic sw_be,
    output logic core_en,
    output logic mod_en,
    output logic syn_en,
    output logic buf_en
);
    // Gate each subsystem with its pin, its bit and the shared power gate
    always_comb begin
        core_en = hw_shdn_n & sw_pd;
        mod_en  = core_en & hw_txen & sw_te;
        syn_en  = core_en & hw_synen;
        buf_en  = core_en & hw_bufen & sw_be;
    end

    // R8
    mod_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en |-> (hw_shdn_n && hw_txen));
    // R11
    shdn_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_shdn_n |-> !(mod_en || syn_en || buf_en));
endmodule

// File: rtl/tw_cfg_slave.sv
// Module: tw_cfg_slave (top)
// Three-wire serial configuration slave. It synchronizes the bus, shifts
// words in, commits them on an enable rise, and drives the subsystem
// enables. Assumes each bus phase lasts at least two clk periods.
module tw_cfg_slave
    import tw_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              sen_n,
    input  logic              hw_shdn_n,
    input  logic              hw_txen,
    input  logic              hw_synen,
    input  logic              hw_bufen,
    output logic [FRAC_W-1:0] frac_word,
    output logic [INT_W-1:0]  int_div,
    output logic [AUXD_W-1:0] aux_div,
    output logic [CFGA_W-1:0] cfg_aux,
    output logic              core_en,
    output logic              mod_en,
    output logic              syn_en,
    output logic              buf_en
);
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_EN  = 2;

    logic [2:0]        s_lvl, s_rise, s_fall;
    logic              shift_en, wr_en;
    logic [WORD_W-1:0] shreg;
    logic [PAY_W-1:0]  cfg_pay;

    tw_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sen_n, sdata, sclk}),
        .lvl      (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    // Qualify shift and commit with the enable level and the shutdown pin
    always_comb begin
        shift_en = s_rise[IDX_CLK] & ~s_lvl[IDX_EN] & hw_shdn_n;
        wr_en    = s_rise[IDX_EN] & hw_shdn_n;
    end

    tw_shift #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (s_lvl[IDX_DAT]),
        .word     (shreg)
    );

    tw_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .word      (shreg),
        .frac_word (frac_word),
        .int_div   (int_div),
        .aux_div   (aux_div),
        .cfg_pay   (cfg_pay)
    );

    // Opaque part of the configuration payload
    always_comb cfg_aux = cfg_pay[PAY_W-1:NSW];

    tw_enables u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_shdn_n (hw_shdn_n),
        .hw_txen   (hw_txen),
        .hw_synen  (hw_synen),
        .hw_bufen  (hw_bufen),
        .sw_pd     (cfg_pay[PD_POS]),
        .sw_te     (cfg_pay[TE_POS]),
        .sw_be     (cfg_pay[BE_POS]),
        .core_en   (core_en),
        .mod_en    (mod_en),
        .syn_en    (syn_en),
        .buf_en    (buf_en)
    );

    // R11: a commit never happens while the shutdown pin is low
    // R11
    shdn_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_shdn_n |-> !wr_en);
    // The serial clock never rises and falls in the same cycle
    sclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_rise[IDX_CLK] && s_fall[IDX_CLK]));
endmodule

// File: tb/tw_cfg_slave_tb.sv
// Directed bench for tw_cfg_slave. Each scenario is a task that checks its
// own results against a bench-side model built from the requirements.
module tw_cfg_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, sen_n = 1'b1;
    logic hw_shdn_n = 1'b1, hw_txen = 1'b1, hw_synen = 1'b1, hw_bufen = 1'b1;
    logic [27:0] frac_word;
    logic [7:0]  int_div;
    logic [5:0]  aux_div;
    logic [10:0] cfg_aux;
    logic core_en, mod_en, syn_en, buf_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model
    logic [15:0] m_sh = '0;
    logic [27:0] m_frac = '0;
    logic [7:0]  m_int = 8'd35;
    logic [5:0]  m_aux = '0;
    logic [13:0] m_cfg = 14'b110;

    always #5 clk = ~clk;

    tw_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sen_n(sen_n),
        .hw_shdn_n(hw_shdn_n), .hw_txen(hw_txen), .hw_synen(hw_synen),
        .hw_bufen(hw_bufen), .frac_word(frac_word), .int_div(int_div),
        .aux_div(aux_div), .cfg_aux(cfg_aux), .core_en(core_en),
        .mod_en(mod_en), .syn_en(syn_en), .buf_en(buf_en)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model
    task automatic check_all(input string tag);
        logic core;
        @(negedge clk);
        core = hw_shdn_n & m_cfg[2];
        check(tag, "frac_word", 32'(frac_word), 32'(m_frac));
        check(tag, "int_div",   32'(int_div),   32'(m_int));
        check(tag, "aux_div",   32'(aux_div),   32'(m_aux));
        check(tag, "cfg_aux",   32'(cfg_aux),   32'(m_cfg[13:3]));
        check(tag, "core_en",   32'(core_en),   32'(core));
        check(tag, "mod_en",    32'(mod_en),    32'(core & hw_txen & m_cfg[1]));
        check(tag, "syn_en",    32'(syn_en),    32'(core & hw_synen));
        check(tag, "buf_en",    32'(buf_en),    32'(core & hw_bufen & m_cfg[0]));
    endtask

    // Send the low nbits of w MSB first, then raise the enable line
    task automatic send(input logic [15:0] w, input int nbits);
        sen_n = 1'b0;
        wait_cyc(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdata = w[i];
            wait_cyc(3);
            sclk = 1'b1;
            if (hw_shdn_n) m_sh = {m_sh[14:0], w[i]};
            wait_cyc(4);
            sclk = 1'b0;
            wait_cyc(3);
        end
        sen_n = 1'b1;
        if (hw_shdn_n) begin
            case (m_sh[1:0])
                2'b00: m_frac[27:14] = m_sh[15:2];
                2'b01: m_frac[13:0]  = m_sh[15:2];
                2'b10: {m_aux, m_int} = m_sh[15:2];
                default: m_cfg = m_sh[15:2];
            endcase
        end
        wait_cyc(6);
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_frac();
        send({14'h3A5C, 2'b00}, 16);
        check_all("R2");
        send({14'h1234, 2'b01}, 16);
        check_all("R3");
        send({14'h0001, 2'b00}, 16);
        check_all("R3");
    endtask

    task automatic t_divide();
        send({6'b101101, 8'd86, 2'b10}, 16);
        check_all("R4");
        send({6'b010010, 8'd251, 2'b10}, 16);
        check_all("R4");
    endtask

    // Sweep the software bits and the pins
    task automatic t_config();
        for (int b = 0; b < 8; b++) begin
            send({11'h5A3, 1'b1, b[1], b[0], 2'b11}, 16);
            check_all("R5");
            for (int p = 0; p < 4; p++) begin
                hw_txen = p[0];
                hw_bufen = p[1];
                wait_cyc(1);
                check_all(b[0] ? "R9" : "R8");
            end
            hw_txen = 1'b1;
            hw_bufen = 1'b1;
        end
    endtask

    task automatic t_power_bits();
        send({11'h000, 1'b0, 1'b1, 1'b1, 2'b11}, 16);
        check_all("R8");
        send({11'h7FF, 1'b1, 1'b1, 1'b1, 2'b11}, 16);
        hw_synen = 1'b0;
        wait_cyc(1);
        check_all("R10");
        hw_synen = 1'b1;
        wait_cyc(1);
        check_all("R10");
    endtask

    // Toggle sclk with the enable line high, then make a short write
    task automatic t_ignore_short();
        send({14'h2AAA, 2'b01}, 16);
        sdata = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; wait_cyc(4);
            sclk = 1'b0; wait_cyc(4);
        end
        send({13'h0, 3'b100}, 3);
        check_all("R6");
        send({14'h0, 2'b01}, 2);
        check_all("R7");
    endtask

    task automatic t_shutdown();
        hw_shdn_n = 1'b0;
        wait_cyc(1);
        check_all("R11");
        send({8'h00, 8'd99, 2'b10}, 16);
        hw_shdn_n = 1'b1;
        wait_cyc(1);
        check_all("R11");
        send({6'b000111, 8'd77, 2'b10}, 16);
        check_all("R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_frac();
        t_divide();
        t_config();
        t_power_bits();
        t_ignore_short();
        t_shutdown();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule